// File: doc/BRIEF.md
# Serial Port with Threshold-Driven FIFO Interrupts

This block is an asynchronous serial transmitter and receiver for a host that talks to it through a small register file. Bytes written to the data register queue in a transmit FIFO and leave on a single line. Each byte is framed with a start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two stop bits. Frames arriving on the receive line are oversampled sixteen times per bit and checked for parity and framing. They are then queued, each with its own error flags, in a receive FIFO that the host drains by reading the data register.

Seven interrupt sources share one request line, and each source can be masked on its own. The FIFO sources follow programmable fill thresholds. The error, break and timeout sources are latched until the host clears them. Clearing the FIFO-enable bit shrinks both queues to a single holding entry.

Register map on `addr`:

| Addr | Access | Content |
|------|--------|---------|
| 0 | W | push `wdata[7:0]` into the transmit FIFO |
| 0 | R | head of the receive FIFO; a read with `rd_en` pops it |
| 1 | R/W | line setup |
| 2 | R/W | divisor |
| 3 | R/W | trigger levels: [2:0] transmit, [5:3] receive |
| 4 | R/W | interrupt mask, [6:0] |
| 5 | R | raw status: [6:0] raw sources, [8] receive FIFO empty, [9] transmit FIFO full, [10] transmitter busy |
| 6 | R | masked sources, [6:0] |
| 7 | W | write 1 to clear latched sources |

Top module: `sercom_uart`

## Requirements
- R1: After reset, `txd` is high and `irq` is low. Register 5 reads 0x0102: the receive FIFO is empty and only the transmit-level source (bit 1) is raw. The line register resets to 0x43, the divisor to 1 and the levels to 0x12.
- R2: The line register is laid out as [1:0] data length minus 5, [2] two stop bits, [3] parity on, [4] even parity, [5] stick parity, [6] FIFO enable and [7] break send. A frame is a low start bit, then the data LSB first, then the parity bit if enabled, then the stop bits at high level. Each bit lasts 16 ticks, and a tick comes every divisor clocks; a divisor of 0 or 1 gives one tick per clock. The line idles high.
- R3: With parity enabled, even parity makes the count of ones across data and parity even, and odd parity makes it odd. With stick set, the parity bit is a constant 0 when even is selected and 1 when odd is selected.
- R4: The receiver accepts a start bit after 8 consecutive low ticks and samples every later bit 16 ticks apart. A low pulse shorter than 8 ticks is ignored. A received word reads as [7:0] data (upper unused bits zero), [8] framing error (a stop bit sampled low), [9] parity mismatch and [10] break.
- R5: Each FIFO holds 16 entries in order. A frame that completes while the receive FIFO is full is dropped and sets raw bit 6 (overrun).
- R6: With FIFO enable cleared, each FIFO holds one entry. A second received byte overruns and is dropped.
- R7: Trigger-level codes 0 to 4 select 2, 4, 8, 12 and 14 entries, and larger codes act as 4. Raw bit 0 is set while the receive count is at or above its level, and raw bit 1 while the transmit count is at or below its level. With the FIFOs disabled, bit 0 means "receive not empty" and bit 1 means "transmit empty".
- R8: Raw bit 2 (timeout) is set once the receive FIFO has held data through 32 bit periods with no byte arriving and no read. It stays set until it is cleared and does not fire again until a new byte arrives or a byte is read.
- R9: Setting break send forces `txd` low. When every sample of a frame, stop bits included, reads low, one word with only the break flag set (value 0x400) is stored, and raw bit 5 is set. The receiver then waits for the line to go high.
- R10: `irq` is the OR of the raw sources ANDed with the mask, and register 6 reads that AND. Writing 1 to a bit of register 7 clears latched bits 2 to 6: timeout, framing (3), parity (4), break (5) and overrun (6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe (pops the receive FIFO at address 0) |
| addr | input | 3 | register address |
| wdata | input | 16 | write data |
| rdata | output | 16 | read data, combinational from `addr` |
| rxd | input | 1 | serial receive line |
| txd | output | 1 | serial transmit line |
| irq | output | 1 | combined masked interrupt |

## Verification
The receive timeout is the hardest case to reach. It needs a byte waiting in the receive FIFO, an idle line and no reads for 512 ticks. It also must not fire a second time after it has been cleared. The bench sends one byte through a loopback of `txd` to `rxd`, stays silent on both sides, and checks the flag once well inside the window and once past it. It then clears the flag and confirms it stays clear. The overrun and break cases come from filling the queue past its capacity and from holding the line low longer than a frame, with the bench driving `rxd` directly.

// File: rtl/sercom_uart_pkg.sv
package sercom_uart_pkg;

  typedef struct packed {
    logic       brk_send;
    logic       fifo_en;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop2;
    logic [1:0] wsel;
  } line_cfg_t;

  typedef struct packed {
    logic       brk;
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_word_t;

  function automatic logic [7:0] data_mask(logic [1:0] wsel);
    return 8'hFF >> (2'd3 - wsel);
  endfunction

  function automatic logic [3:0] data_bits(logic [1:0] wsel);
    return 4'd5 + 4'(wsel);
  endfunction

  function automatic logic par_bit(logic [7:0] d, line_cfg_t c);
    logic ones_odd;
    ones_odd = ^(d & data_mask(c.wsel));
    if (c.stick) return ~c.even;
    return c.even ? ones_odd : ~ones_odd;
  endfunction

  // start + data + parity + stop bits
  function automatic logic [3:0] frame_len(line_cfg_t c);
    return 4'd2 + data_bits(c.wsel) + 4'(c.par_en) + 4'(c.stop2);
  endfunction

  function automatic logic [11:0] tx_bits(logic [7:0] d, line_cfg_t c);
    logic [11:0] v;
    logic [3:0]  w;
    w    = data_bits(c.wsel);
    v    = '1;
    v[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < w) v[i+1] = d[i];
    if (c.par_en) v[w + 4'd1] = par_bit(d, c);
    return v;
  endfunction

  function automatic int unsigned trig_level(logic [2:0] sel, int unsigned depth);
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return depth * 3 / 4;
      default: return depth * 7 / 8;
    endcase
  endfunction

endpackage

// File: rtl/sercom_uart_fifo.sv
module sercom_uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_one,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = cap_one ? !empty : (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/sercom_uart_tx.sv
module sercom_uart_tx
  import sercom_uart_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  line_cfg_t cfg,
  input  logic      have,
  input  logic [7:0] din,
  output logic      pop,
  output logic      busy,
  output logic      txd
);
  logic [11:0] sh;
  logic [3:0]  left, sub;

  assign busy = (left != '0);
  assign pop  = !busy && have;
  assign txd  = !cfg.brk_send && (busy ? sh[0] : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      sub  <= '0;
    end else if (pop) begin
      sh   <= tx_bits(din, cfg);
      left <= frame_len(cfg);
      sub  <= '0;
    end else if (busy && tick) begin
      sub <= sub + 4'd1;
      if (sub == 4'd15) begin
        sh   <= {1'b1, sh[11:1]};
        left <= left - 4'd1;
      end
    end
  end
endmodule

// File: rtl/sercom_uart_rx.sv
module sercom_uart_rx
  import sercom_uart_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  line_cfg_t cfg,
  input  logic      rxd,
  output logic      push,
  output rx_word_t  word,
  output logic      idle
);
  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_HOLD} rx_st_e;

  rx_st_e      st;
  logic [1:0]  sync;
  logic        rxs;
  logic [3:0]  sub, idx, w, nlen;
  logic [11:0] smp, vec, live;
  logic        last, stop_bad, all_low, perr;

  assign rxs  = sync[1];
  assign w    = data_bits(cfg.wsel);
  assign nlen = frame_len(cfg) - 4'd1;          // samples after the start bit
  assign last = (idx == nlen - 4'd1);
  assign live = (12'h001 << nlen) - 12'h001;

  always_comb begin
    vec      = smp;
    vec[idx] = rxs;
  end

  assign stop_bad = !vec[w + 4'(cfg.par_en)] ||
                    (cfg.stop2 && !vec[w + 4'(cfg.par_en) + 4'd1]);
  assign all_low  = ((vec & live) == '0);
  assign perr     = cfg.par_en && (vec[w] != par_bit(vec[7:0], cfg));

  always_comb begin
    if (all_low) word = '{brk: 1'b1, perr: 1'b0, ferr: 1'b0, data: 8'h00};
    else         word = '{brk: 1'b0, perr: perr, ferr: stop_bad,
                          data: vec[7:0] & data_mask(cfg.wsel)};
  end

  assign push = (st == RX_BITS) && tick && (sub == 4'd15) && last;
  assign idle = (st == RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      st   <= RX_IDLE;
      sub  <= '0;
      idx  <= '0;
      smp  <= '0;
    end else begin
      sync <= {sync[0], rxd};
      if (tick) begin
        case (st)
          RX_IDLE: begin
            if (rxs) sub <= '0;
            else if (sub == 4'd7) begin
              st  <= RX_BITS;
              sub <= '0;
              idx <= '0;
              smp <= '0;
            end else sub <= sub + 4'd1;
          end
          RX_BITS: begin
            sub <= sub + 4'd1;
            if (sub == 4'd15) begin
              smp <= vec;
              idx <= idx + 4'd1;
              if (last) st <= stop_bad ? RX_HOLD : RX_IDLE;
            end
          end
          default: if (rxs) begin
            st  <= RX_IDLE;
            sub <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
  import sercom_uart_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DIVW     = 16,
  parameter int OVS      = 16,
  parameter int IDLE_BITS = 32,
  localparam int CW      = $clog2(DEPTH) + 1,
  localparam int TO_TICKS = OVS * IDLE_BITS,
  localparam int TOW     = $clog2(TO_TICKS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  line_cfg_t       line;
  logic [DIVW-1:0] div, bcnt;
  logic [5:0]      lvl;
  logic [6:0]      mask, raw;
  logic            tick, line_brk;
  logic            to_f, fe_f, pe_f, brk_f, ovr_f;

  logic            tx_push, tx_pop, tx_full, tx_empty, tx_busy;
  logic [7:0]      tx_dout;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            rx_push, rx_pop, rx_full, rx_empty, rx_idle, rx_store;
  rx_word_t        rx_word, rx_dout;
  logic [TOW-1:0]  to_cnt;
  logic            to_run, to_hit, rx_lvl_hit, tx_lvl_hit;
  logic [6:0]      clr;

  assign line_brk = line.brk_send;
  assign tick     = (div <= DIVW'(1)) || (bcnt == div - DIVW'(1));
  assign tx_push  = wr_en && (addr == 3'd0);
  assign rx_pop   = rd_en && (addr == 3'd0);
  assign rx_store = rx_push && !rx_full;
  assign clr      = (wr_en && addr == 3'd7) ? wdata[6:0] : 7'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? '0 : bcnt + DIVW'(1);
  end

  sercom_uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .cap_one(!line.fifo_en), .push(tx_push), .din(wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  sercom_uart_fifo #(.W($bits(rx_word_t)), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .cap_one(!line.fifo_en), .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  sercom_uart_tx u_tx (
    .clk, .rst_n, .tick, .cfg(line), .have(!tx_empty), .din(tx_dout),
    .pop(tx_pop), .busy(tx_busy), .txd);

  sercom_uart_rx u_rx (
    .clk, .rst_n, .tick, .cfg(line), .rxd,
    .push(rx_push), .word(rx_word), .idle(rx_idle));

  // receive timeout: idle line with data waiting
  assign to_run = rx_idle && !rx_empty;
  assign to_hit = tick && to_run && !rx_push && !rx_pop && (to_cnt == TOW'(TO_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) to_cnt <= '0;
    else if (rx_push || rx_pop) to_cnt <= '0;
    else if (tick && to_run && to_cnt != TOW'(TO_TICKS)) to_cnt <= to_cnt + TOW'(1);
  end

  assign rx_lvl_hit = line.fifo_en ? (rx_cnt >= CW'(trig_level(lvl[5:3], DEPTH))) : !rx_empty;
  assign tx_lvl_hit = line.fifo_en ? (tx_cnt <= CW'(trig_level(lvl[2:0], DEPTH))) : tx_empty;
  assign raw = {ovr_f, brk_f, pe_f, fe_f, to_f, tx_lvl_hit, rx_lvl_hit};
  assign irq = |(raw & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line  <= line_cfg_t'(8'h43);
      div   <= DIVW'(1);
      lvl   <= 6'o22;
      mask  <= '0;
      to_f  <= 1'b0;
      fe_f  <= 1'b0;
      pe_f  <= 1'b0;
      brk_f <= 1'b0;
      ovr_f <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          3'd1: line <= line_cfg_t'(wdata[7:0]);
          3'd2: div  <= DIVW'(wdata);
          3'd3: lvl  <= wdata[5:0];
          3'd4: mask <= wdata[6:0];
          default: ;
        endcase
      end
      to_f  <= to_hit || (to_f && !clr[2]);
      fe_f  <= (rx_store && rx_word.ferr) || (fe_f && !clr[3]);
      pe_f  <= (rx_store && rx_word.perr) || (pe_f && !clr[4]);
      brk_f <= (rx_store && rx_word.brk)  || (brk_f && !clr[5]);
      ovr_f <= (rx_push && rx_full)       || (ovr_f && !clr[6]);
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = {5'd0, rx_dout};
      3'd1:    rdata = {8'd0, line};
      3'd2:    rdata = 16'(div);
      3'd3:    rdata = {10'd0, lvl};
      3'd4:    rdata = {9'd0, mask};
      3'd5:    rdata = {5'd0, tx_busy, tx_full, rx_empty, 1'b0, raw};
      3'd6:    rdata = {9'd0, raw & mask};
      default: rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/sercom_uart_chk.sv
module sercom_uart_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          tx_busy,
  input logic          line_brk,
  input logic          tx_pop,
  input logic          tx_empty,
  input logic          rx_push,
  input logic          rx_full,
  input logic          rx_empty,
  input logic [CW-1:0] rx_cnt,
  input logic [6:0]    raw,
  input logic [6:0]    mask,
  input logic          irq
);
  AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !line_brk) |-> txd); // R2

  AST_TX_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R5

  AST_RX_WITHIN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH)); // R5

  AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> raw[6]); // R5

  AST_TIMEOUT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[2]) |-> !rx_empty); // R8

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != 7'd0)); // R10
endmodule

bind sercom_uart sercom_uart_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .line_brk(line_brk),
  .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full),
  .rx_empty(rx_empty), .rx_cnt(rx_cnt), .raw(raw), .mask(mask), .irq(irq));

// File: tb/sercom_uart_tb.sv
module sercom_uart_tb;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rx_drv = 1'b1, loop = 1'b0, done = 1'b0;
  logic        txd, irq;
  wire         rxd = loop ? txd : rx_drv;
  int          n_run = 0, n_fail = 0, bt = 16;

  always #2 clk = ~clk;

  sercom_uart u_dut (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
                     .rxd, .txd, .irq);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // pm: 0 none, 1 even, 2 odd, 3 stick 0, 4 stick 1
  function automatic logic [15:0] line_of(int w, int pm, bit s2, bit fifo);
    return 16'((w - 5) | (int'(s2) << 2) | (int'(pm != 0) << 3) |
               (int'(pm == 1 || pm == 3) << 4) | (int'(pm >= 3) << 5) | (int'(fifo) << 6));
  endfunction

  function automatic logic [11:0] frame_of(logic [7:0] d, int w, int pm, bit s2, output int n);
    logic [11:0] f = '1;
    int k = 1, ones = 0;
    f[0] = 1'b0;
    for (int i = 0; i < w; i++) begin f[k] = d[i]; ones += int'(d[i]); k++; end
    if (pm != 0) begin
      case (pm)
        1: f[k] = ones[0];
        2: f[k] = ~ones[0];
        3: f[k] = 1'b0;
        default: f[k] = 1'b1;
      endcase
      k++;
    end
    n = k + (s2 ? 2 : 1);
    return f;
  endfunction

  task automatic cap_tx(input int n, output logic [11:0] got);
    int g = 0;
    got = '1;
    while (txd !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
    idle(bt / 2);
    for (int i = 0; i < n; i++) begin got[i] = txd; idle(bt); end
  endtask

  task automatic send_rx(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin rx_drv = f[i]; idle(bt); end
    rx_drv = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [11:0] got, ef;
    int n;
    logic [15:0] sent [16];
    bit seq_ok;
    void'($urandom(32'd4711));
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    chk("R1 txd idle", 32'(txd), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    rd(3'd5, v); chk("R1 status", 32'(v), 32'h0102);
    rd(3'd1, v); chk("R1 line", 32'(v), 32'h43);

    // R2 R3 R4 random frames, checked on the wire and through loopback
    loop = 1'b1;
    for (int it = 0; it < 10; it++) begin
      int w, pm, dv; bit s2; logic [7:0] d;
      w = 5 + int'($urandom % 4); pm = int'($urandom % 5); s2 = bit'($urandom % 2);
      dv = 1 + int'($urandom % 3); d = 8'($urandom);
      bt = 16 * dv;
      wr(3'd2, 16'(dv)); wr(3'd1, line_of(w, pm, s2, 1'b1));
      ef = frame_of(d, w, pm, s2, n);
      wr(3'd0, {8'd0, d});
      cap_tx(n, got);
      chk("R2 R3 frame on txd", 32'(got & ((12'h1 << n) - 1)), 32'(ef & ((12'h1 << n) - 1)));
      idle(bt);
      rd(3'd0, v);
      chk("R4 loopback word", 32'(v), 32'(d & 8'((1 << w) - 1)));
    end
    bt = 16; wr(3'd2, 16'd1); wr(3'd1, 16'h43); wr(3'd7, 16'h7C);

    // R4 short low pulse ignored
    loop = 1'b0;
    rx_drv = 1'b0; idle(4); rx_drv = 1'b1; idle(300);
    rd(3'd5, v); chk("R4 glitch ignored, rx empty", 32'(v[8]), 32'd1);

    // R4 parity mismatch and framing error
    wr(3'd1, line_of(8, 1, 1'b0, 1'b1));
    ef = frame_of(8'h35, 8, 1, 1'b0, n); ef[9] = ~ef[9];
    send_rx(ef, n); idle(20);
    rd(3'd0, v); chk("R4 parity flag", 32'(v), 32'h235);
    rd(3'd5, v); chk("R4 raw parity", 32'(v[4]), 32'd1);
    ef = frame_of(8'h0F, 8, 1, 1'b0, n); ef[10] = 1'b0;
    send_rx(ef, n); idle(20);
    rd(3'd0, v); chk("R4 framing flag", 32'(v), 32'h10F);
    rd(3'd5, v); chk("R4 raw framing", 32'(v[3]), 32'd1);

    // R9 break detect
    wr(3'd1, 16'h43); wr(3'd7, 16'h7C);
    rx_drv = 1'b0; idle(12 * bt); rx_drv = 1'b1; idle(20);
    rd(3'd0, v); chk("R9 break word", 32'(v), 32'h400);
    rd(3'd5, v); chk("R9 raw break", 32'(v[5]), 32'd1);

    // R10 mask and clear
    wr(3'd4, 16'h20); idle(2);
    chk("R10 irq with mask", 32'(irq), 32'd1);
    rd(3'd6, v); chk("R10 masked view", 32'(v), 32'h20);
    wr(3'd7, 16'h20); idle(2);
    chk("R10 irq after clear", 32'(irq), 32'd0);
    wr(3'd4, 16'h0);

    // R9 break send
    wr(3'd1, 16'hC3); idle(3); chk("R9 txd forced low", 32'(txd), 32'd0);
    wr(3'd1, 16'h43); idle(3); chk("R9 txd released", 32'(txd), 32'd1);

    // R7 trigger levels: rx code 1 (4 entries), tx code 0 (2 entries)
    wr(3'd7, 16'h7C); loop = 1'b1;
    wr(3'd3, 16'h08);
    for (int i = 0; i < 3; i++) wr(3'd0, 16'(8'h40 + i));
    idle(3 * 160 + 60);
    rd(3'd5, v); chk("R7 rx below level", 32'(v[0]), 32'd0);
    wr(3'd0, 16'h43); idle(220);
    rd(3'd5, v); chk("R7 rx at level", 32'(v[0]), 32'd1);
    for (int i = 0; i < 4; i++) rd(3'd0, v);
    for (int i = 0; i < 5; i++) wr(3'd0, 16'(8'h50 + i));
    rd(3'd5, v); chk("R7 tx above level", 32'(v[1]), 32'd0);
    idle(5 * 160 + 100);
    rd(3'd5, v); chk("R7 tx drained", 32'(v[1]), 32'd1);
    for (int i = 0; i < 5; i++) rd(3'd0, v);
    wr(3'd3, 16'h12);

    // R8 receive timeout
    wr(3'd7, 16'h7C);
    wr(3'd0, 16'h5A); idle(160 + 16 + 320);
    rd(3'd5, v); chk("R8 no timeout yet", 32'(v[2]), 32'd0);
    idle(300);
    rd(3'd5, v); chk("R8 timeout raised", 32'(v[2]), 32'd1);
    wr(3'd7, 16'h04); idle(40);
    rd(3'd5, v); chk("R8 timeout cleared stays clear", 32'(v[2]), 32'd0);
    rd(3'd0, v); chk("R8 waiting byte", 32'(v), 32'h5A);

    // R5 full 16-entry queue, overrun on the 17th
    wr(3'd7, 16'h7C);
    for (int i = 0; i < 16; i++) begin
      sent[i] = 16'($urandom % 256); wr(3'd0, sent[i]);
    end
    idle(16 * 160 + 100);
    rd(3'd5, v); chk("R5 sixteen fit", 32'(v[6]), 32'd0);
    wr(3'd0, 16'hEE); idle(200);
    rd(3'd5, v); chk("R5 overrun", 32'(v[6]), 32'd1);
    seq_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, v);
      if (v !== sent[i]) seq_ok = 1'b0;
    end
    chk("R5 order kept", 32'(seq_ok), 32'd1);
    rd(3'd5, v); chk("R5 extra byte dropped", 32'(v[8]), 32'd1);

    // R6 single holding entry
    wr(3'd7, 16'h7C); wr(3'd1, 16'h03);
    wr(3'd0, 16'hA1); idle(200);
    wr(3'd0, 16'hB2); idle(200);
    rd(3'd5, v); chk("R6 overrun at one entry", 32'(v[6]), 32'd1);
    rd(3'd0, v); chk("R6 first byte kept", 32'(v), 32'hA1);
    rd(3'd5, v); chk("R6 second dropped", 32'(v[8]), 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule